// File: doc/BRIEF.md
# Capture Timer Channel

This block is one 16-bit timer channel working as a measurement unit. A free-running counter advances either on every clock or once every 128 clocks. A prescaler provides that rate, and the counter can be stopped, started and restarted through a control register. The block watches a single capture line, the A-side line. A programmable edge on that line copies the running count into capture register A, and another programmable edge copies it into capture register B. Software subtracts the two captures to get a pulse width or a period.

A second input line, the B-side line, enters the block but never loads a capture register. Only its synchronized level can be read, so software can see that it is active. Three events set sticky flags in a status register: counter wrap, a load of register A and a load of register B. Reading the status register returns the flags and clears them in the same access.

An eight-bit interrupt mask is unmasked through one write-one address and masked through another. The interrupt output is a registered OR of the flags that are not masked. The register interface is a plain strobe bus with a three-bit word address. Read data appears the cycle after the read strobe.

Top module: `cap_timer_chan`

## Requirements
- R1: After reset the counter reads 0 and is stopped, the status flags and the interrupt mask are 0, and the interrupt output is low.
- R2: A write to the control address 0 acts as follows: bit 0 starts the counter clock, and bit 1 stops it, winning over bit 0 when both are set. Bit 2 clears the counter and the prescaler to zero. Writing bits 0 and 2 together restarts from zero with the clock running, so an immediate read returns 0 and the next read returns 1.
- R3: While the counter clock is stopped, the count holds its value.
- R4: Mode bit 0 (mode address 1) selects the count rate: 0 advances the counter every clock, and 1 advances it once every 128 clocks.
- R5: Mode bits [2:1] choose the A-side edge that loads capture register A, and mode bits [4:3] choose the edge that loads capture register B. The codes are 0 none, 1 rising, 2 falling and 3 both. Both loads use the same latency, so the difference between the two captures equals the pulse length in counter steps.
- R6: Activity on the B-side line never loads either capture register. Its synchronized level reads back as status bit 9, and the A-side level reads back as status bit 8.
- R7: The counter wraps from 0xFFFF to 0, sets status bit 0 when it does, and keeps running and wrapping with no capture edges present.
- R8: Status bit 5 flags a load of capture register A, and status bit 6 flags a load of capture register B.
- R9: A read of the status address 5 returns the flags and clears bits 7:0. An event that arrives in the same cycle as the clearing read still leaves its flag set.
- R10: A write to address 6 sets the mask bits written as one. A write to address 7 clears the mask bits written as one, so 0xFF masks every source. A read of either address returns the mask.
- R11: The interrupt output is the registered OR of the status flags ANDed with the mask. It follows a flag change one cycle later.
- R12: Reads of addresses 2, 3 and 4 return the count, capture A and capture B. Read data is valid from the clock edge that samples the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_a_in | input | 1 | A-side capture line (asynchronous) |
| cap_b_in | input | 1 | B-side line, level only (asynchronous) |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches the following every cycle:
- Each capture register changes only in the cycle after its own load event.
- The count holds while the clock is stopped, and is zero after a software restart.
- A wrap at 0xFFFF lands on zero with the overflow flag raised, and an overflow event always sets its flag even against a clearing read.
- The mask moves only on writes, and a zero mask keeps the interrupt low.

Only the bench scenarios show the following:
- Measured pulse lengths at both count rates.
- Each edge-select code.
- That B-side toggling leaves the captures untouched.
- The clear-on-read sequence and the interrupt rising and falling around it.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_MODE  = 3'd1,
        RA_COUNT = 3'd2,
        RA_CAPA  = 3'd3,
        RA_CAPB  = 3'd4,
        RA_STAT  = 3'd5,
        RA_IEN   = 3'd6,
        RA_IDIS  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // bit 0 rate select, [2:1] A-register edge, [4:3] B-register edge
    typedef struct packed {
        edge_sel_e b_sel;
        edge_sel_e a_sel;
        logic      div_on;
    } mode_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int FLAG_W = 8;
    localparam int WD_W   = 8;

    localparam int ST_OVF = 0;
    localparam int ST_LDA = 5;
    localparam int ST_LDB = 6;
    localparam int ST_LVA = 8;
    localparam int ST_LVB = 9;

    localparam int CT_EN  = 0;
    localparam int CT_DIS = 1;
    localparam int CT_RST = 2;

    function automatic logic edge_match(edge_sel_e sel, edge_t ev);
        case (sel)
            EDGE_RISE: return ev.rise;
            EDGE_FALL: return ev.fall;
            EDGE_BOTH: return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_timer_presc.sv
module cap_timer_presc #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic div_on,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt_q <= '0;
        end else if (run && div_on) begin
            pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
        end
    end

    assign tick = run & (~div_on | (pcnt_q == LAST));

endmodule

// File: rtl/cap_timer_edge.sv
module cap_timer_edge
    import cap_timer_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_in,
    output edge_t edge_q,
    output logic  level
);
    logic [SYNC_N:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            edge_q <= '0;
        end else begin
            sh_q        <= {sh_q[SYNC_N-1:0], line_in};
            edge_q.rise <= sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
            edge_q.fall <= ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
        end
    end

    assign level = sh_q[SYNC_N-1];

endmodule

// File: rtl/cap_timer_core.sv
module cap_timer_core
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  edge_t            a_edge,
    input  mode_t            mode,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] capa_q,
    output logic [CNT_W-1:0] capb_q,
    output logic             ovf_evt,
    output logic             lda_evt,
    output logic             ldb_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign ovf_evt = tick & ~clr & (cnt_q == CNT_MAX);
    assign lda_evt = edge_match(mode.a_sel, a_edge);
    assign ldb_evt = edge_match(mode.b_sel, a_edge);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capa_q <= '0;
            capb_q <= '0;
        end else begin
            if (lda_evt) capa_q <= cnt_q;
            if (ldb_evt) capb_q <= cnt_q;
        end
    end

endmodule

// File: rtl/cap_timer_regs.sv
module cap_timer_regs
    import cap_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [WD_W-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  capa,
    input  logic [CNT_W-1:0]  capb,
    input  logic              ovf_evt,
    input  logic              lda_evt,
    input  logic              ldb_evt,
    input  logic              lvl_a,
    input  logic              lvl_b,
    output mode_t             mode_q,
    output logic              run_q,
    output logic              swrst,
    output logic [FLAG_W-1:0] flags_q,
    output logic [FLAG_W-1:0] mask_q
);
    reg_addr_e         ra;
    logic              wr_ctrl;
    logic              rd_stat;
    logic [FLAG_W-1:0] evt_vec;
    logic [CNT_W-1:0]  stat_word;

    assign ra      = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_wr && (ra == RA_CTRL);
    assign swrst   = wr_ctrl && bus_wdata[CT_RST];
    assign rd_stat = bus_rd && (ra == RA_STAT);

    always_comb begin
        evt_vec         = '0;
        evt_vec[ST_OVF] = ovf_evt;
        evt_vec[ST_LDA] = lda_evt;
        evt_vec[ST_LDB] = ldb_evt;
    end

    always_comb begin
        stat_word                = '0;
        stat_word[FLAG_W-1:0]    = flags_q;
        stat_word[ST_LVA]        = lvl_a;
        stat_word[ST_LVB]        = lvl_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            mode_q <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            case (ra)
                RA_CTRL: begin
                    if (bus_wdata[CT_DIS])     run_q <= 1'b0;
                    else if (bus_wdata[CT_EN]) run_q <= 1'b1;
                end
                RA_MODE: mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
                RA_IEN:  mask_q <= mask_q | bus_wdata;
                RA_IDIS: mask_q <= mask_q & ~bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (rd_stat ? '0 : flags_q) | evt_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (ra)
                RA_CTRL:  bus_rdata <= {{(CNT_W-1){1'b0}}, run_q};
                RA_MODE:  bus_rdata <= {{(CNT_W-MODE_W){1'b0}}, mode_q};
                RA_COUNT: bus_rdata <= cnt;
                RA_CAPA:  bus_rdata <= capa;
                RA_CAPB:  bus_rdata <= capb;
                RA_STAT:  bus_rdata <= stat_word;
                default:  bus_rdata <= {{(CNT_W-FLAG_W){1'b0}}, mask_q};
            endcase
        end
    end

endmodule

// File: rtl/cap_timer_chan.sv
module cap_timer_chan
    import cap_timer_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRESC_DIV = 128,
    parameter int SYNC_N    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_a_in,
    input  logic             cap_b_in,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WD_W-1:0]  bus_wdata,
    input  logic             bus_rd,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    mode_t             mode_q;
    logic              run_q;
    logic              swrst;
    logic              tick;
    edge_t             a_edge;
    logic              lvl_a;
    logic              lvl_b;
    logic [SYNC_N-1:0] bsync_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  capa_q;
    logic [CNT_W-1:0]  capb_q;
    logic              ovf_evt;
    logic              lda_evt;
    logic              ldb_evt;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] mask_q;
    logic              irq_q;

    cap_timer_presc #(.DIV(PRESC_DIV)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .clr    (swrst),
        .run    (run_q),
        .div_on (mode_q.div_on),
        .tick   (tick)
    );

    cap_timer_edge #(.SYNC_N(SYNC_N)) u_edge_a (
        .clk     (clk),
        .rst     (rst),
        .line_in (cap_a_in),
        .edge_q  (a_edge),
        .level   (lvl_a)
    );

    // B-side line: level synchronizer only, no path into the capture logic
    always_ff @(posedge clk) begin
        if (rst) bsync_q <= '0;
        else     bsync_q <= {bsync_q[SYNC_N-2:0], cap_b_in};
    end
    assign lvl_b = bsync_q[SYNC_N-1];

    cap_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .clr     (swrst),
        .a_edge  (a_edge),
        .mode    (mode_q),
        .cnt_q   (cnt_q),
        .capa_q  (capa_q),
        .capb_q  (capb_q),
        .ovf_evt (ovf_evt),
        .lda_evt (lda_evt),
        .ldb_evt (ldb_evt)
    );

    cap_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .cnt       (cnt_q),
        .capa      (capa_q),
        .capb      (capb_q),
        .ovf_evt   (ovf_evt),
        .lda_evt   (lda_evt),
        .ldb_evt   (ldb_evt),
        .lvl_a     (lvl_a),
        .lvl_b     (lvl_b),
        .mode_q    (mode_q),
        .run_q     (run_q),
        .swrst     (swrst),
        .flags_q   (flags_q),
        .mask_q    (mask_q)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(flags_q & mask_q);
    end
    assign irq = irq_q;

endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] capa,
    input logic [CNT_W-1:0] capb,
    input logic             lda,
    input logic             ldb,
    input logic             ovf,
    input logic             tick,
    input logic             run,
    input logic             swrst,
    input logic [7:0]       flags,
    input logic [7:0]       mask,
    input logic             wr,
    input logic             irq
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    AST_SWRST_ZERO: assert property (@(posedge clk) disable iff (rst)
        swrst |=> (cnt == '0)); // R2

    AST_CLK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !swrst) |=> $stable(cnt)); // R3

    AST_A_LOAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(capa) |-> $past(lda)); // R5

    AST_B_LOAD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(capb) |-> $past(ldb)); // R6

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == CMAX && tick && !swrst) |=> (cnt == '0 && flags[0])); // R7

    AST_OVF_WINS: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flags[0]); // R9

    AST_MASK_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mask) |-> $past(wr)); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(mask == 8'h00) |-> !irq); // R11

endmodule

bind cap_timer_chan cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cnt   (cnt_q),
    .capa  (capa_q),
    .capb  (capb_q),
    .lda   (lda_evt),
    .ldb   (ldb_evt),
    .ovf   (ovf_evt),
    .tick  (tick),
    .run   (run_q),
    .swrst (swrst),
    .flags (flags_q),
    .mask  (mask_q),
    .wr    (bus_wr),
    .irq   (irq)
);

// File: tb/cap_timer_chan_tb.sv
module cap_timer_chan_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_a_in = 1'b0;
    logic        cap_b_in = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cap_timer_chan u_dut (
        .clk       (clk),
        .rst       (rst),
        .cap_a_in  (cap_a_in),
        .cap_b_in  (cap_b_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output int d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic pulse_a(input int n);
        @(negedge clk);
        cap_a_in = 1'b1;
        repeat (n) @(negedge clk);
        cap_a_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        int v;
        chk("R1 irq after reset", int'(irq), 0);
        reg_rd(3'd2, v); chk("R1 count after reset", v, 0);
        reg_rd(3'd5, v); chk("R1 status after reset", v, 0);
        reg_rd(3'd6, v); chk("R1 mask after reset", v, 0);
        repeat (50) @(posedge clk);
        reg_rd(3'd2, v); chk("R1 R3 count held while stopped", v, 0);
    endtask

    task automatic t_restart;
        int v;
        reg_wr(3'd1, 8'h12);
        reg_wr(3'd0, 8'h05);
        reg_rd(3'd2, v); chk("R2 count right after restart", v, 0);
        reg_rd(3'd2, v); chk("R2 count one cycle later", v, 1);
        reg_rd(3'd0, v); chk("R2 R12 run bit reads back", v, 1);
    endtask

    task automatic t_width;
        int a, b, s;
        reg_rd(3'd5, s);
        pulse_a(37);
        reg_rd(3'd3, a); reg_rd(3'd4, b);
        chk("R5 R12 rise-to-fall width", b - a, 37);
        reg_rd(3'd5, s); chk("R8 both load flags set", s, 'h60);
        reg_rd(3'd5, s); chk("R9 status cleared by read", s, 0);
    endtask

    task automatic t_edge_codes;
        int a, b, s;
        reg_wr(3'd1, 8'h0C);
        pulse_a(20);
        reg_rd(3'd3, a); reg_rd(3'd4, b);
        chk("R5 fall into A, rise into B", a - b, 20);
        reg_rd(3'd5, s);
        reg_wr(3'd1, 8'h10);
        reg_rd(3'd3, a);
        pulse_a(12);
        reg_rd(3'd5, s); chk("R5 R8 A edge none, B only", s, 'h40);
        reg_rd(3'd3, b); chk("R5 A held with code none", b, a);
    endtask

    task automatic t_b_ignored;
        int a0, b0, a1, b1, s;
        reg_wr(3'd1, 8'h12);
        reg_rd(3'd5, s);
        reg_rd(3'd3, a0); reg_rd(3'd4, b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); cap_b_in = ~cap_b_in;
            repeat (5) @(negedge clk);
        end
        cap_b_in = 1'b1;
        repeat (6) @(negedge clk);
        reg_rd(3'd5, s); chk("R6 B level only, no load flags", s, 'h200);
        reg_rd(3'd3, a1); chk("R6 capture A untouched by B line", a1, a0);
        reg_rd(3'd4, b1); chk("R6 capture B untouched by B line", b1, b0);
        cap_b_in = 1'b0;
        @(negedge clk); cap_a_in = 1'b1;
        repeat (6) @(negedge clk);
        reg_rd(3'd5, s); chk("R6 A level bit", s & 'h100, 'h100);
        cap_a_in = 1'b0;
        repeat (8) @(negedge clk);
        reg_rd(3'd5, s);
    endtask

    task automatic t_irq;
        int s;
        reg_wr(3'd6, 8'h40);
        reg_rd(3'd6, s); chk("R10 mask set by enable write", s, 'h40);
        pulse_a(10);
        chk("R11 irq on unmasked B load", int'(irq), 1);
        reg_rd(3'd5, s);
        repeat (2) @(posedge clk); #1;
        chk("R9 R11 irq drops after clearing read", int'(irq), 0);
        reg_wr(3'd7, 8'hFF);
        reg_rd(3'd7, s); chk("R10 mask cleared by disable write", s, 0);
        pulse_a(10);
        chk("R11 irq stays low when masked", int'(irq), 0);
        reg_rd(3'd5, s); chk("R8 flags still raised when masked", s, 'h60);
    endtask

    task automatic t_divided;
        int a, b, s;
        reg_wr(3'd1, 8'h13);
        reg_wr(3'd0, 8'h05);
        reg_rd(3'd2, a);
        repeat (1279) @(posedge clk);
        reg_rd(3'd2, b);
        chk("R4 divided rate over 1280 clocks", b - a, 10);
        reg_rd(3'd5, s);
        pulse_a(1280);
        reg_rd(3'd3, a); reg_rd(3'd4, b);
        chk("R4 R5 divided pulse width", b - a, 10);
    endtask

    task automatic t_stop;
        int a, b;
        reg_wr(3'd0, 8'h03);
        reg_rd(3'd2, a);
        repeat (300) @(posedge clk);
        reg_rd(3'd2, b);
        chk("R2 R3 disable wins, count holds", b, a);
    endtask

    task automatic t_overflow;
        int s, c;
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd6, 8'h01);
        reg_wr(3'd0, 8'h05);
        reg_rd(3'd5, s);
        repeat (65400) @(posedge clk);
        reg_rd(3'd5, s); chk("R7 no wrap flag before 0xFFFF", s & 1, 0);
        repeat (200) @(posedge clk); #1;
        chk("R11 irq on overflow", int'(irq), 1);
        reg_rd(3'd5, s); chk("R7 wrap flag set without edges", s & 1, 1);
        reg_rd(3'd2, c); chk("R7 count wrapped to small value", int'(c < 400), 1);
        reg_rd(3'd5, s); chk("R9 wrap flag cleared by read", s & 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_restart();
        t_width();
        t_edge_codes();
        t_b_ignored();
        t_irq();
        t_divided();
        t_stop();
        t_overflow();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule